// File: doc/BRIEF.md
# Ten-to-N Block Lane Gearbox

This block sits on the physical side of a 100G link. It takes rows of ten 66-bit encoded blocks, one block per electrical lane, and spreads them over a smaller number of output lanes. The number of output lanes, N, is set by a parameter to 1, 2, 4, 5 or 10. Blocks are numbered in global order: within a row, lane 0 comes first and lane 9 last, and rows follow one another. Output lane k carries every block whose number b satisfies b mod N = k. Each output cycle therefore carries N blocks that are consecutive in that order.

A row store of 20 blocks absorbs the rate difference between the wide input and the narrow output. A row is accepted only when there is room for all ten blocks, so the input is held back with backpressure whenever N is below ten. Every block, including the periodic alignment blocks, is passed through bit for bit and is never rebuilt. When N divides ten, each input lane always lands on the same output lane. When it does not (N = 4), the mapping shifts from row to row and repeats after lcm(10, N) blocks. A small pattern counter reports where the current output cycle lies inside that repeat.

Top module: `ten_to_n_gearbox`

## Requirements
- R1: Holding `rst_n` low across a clock edge clears the store. After that edge, `out_valid` is 0, `in_ready` is 1 and `pat_pos` is 0, whatever was in the store before.
- R2: Blocks are numbered globally from 0 after reset: block 10·j + i is input lane i (bits 66·i+65 down to 66·i) of the j-th accepted row. Output cycle m places block m·N + k on output lane k (bits 66·k+65 down to 66·k).
- R3: `out_valid` is 1 exactly when the store holds at least N blocks. No output cycle carries fewer than N blocks.
- R4: `in_ready` is 1 exactly when the store has room for ten more blocks, before any read in the same cycle is counted (occupancy ≤ 10 with the default depth of 20). The store never holds more than its depth.
- R5: `pat_pos` is the global number of the block on output lane 0, taken modulo lcm(10, N). It is 0 after reset, and its values are 0, 4, 8, 12, 16 for N = 4.
- R6: Each block, including its 2-bit sync header and including alignment blocks, leaves exactly as it entered.
- R7: While rows are offered on every cycle, `out_valid` stays high on every cycle after the first accepted row.
- R8: Values on `in_blocks` while `in_valid` is 0 never reach the outputs.
- R9: When input stops and fewer than N blocks are left, they are held with `out_valid` low. The next accepted row continues the numbering from those held blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A row of ten blocks is offered |
| in_ready | output | 1 | The store can take a whole row this cycle |
| in_blocks | input | 660 | Ten 66-bit blocks; lane i at bits 66·i+65 down to 66·i |
| out_valid | output | 1 | N blocks are presented on the output lanes |
| out_blocks | output | 66·N | N 66-bit blocks; lane k at bits 66·k+65 down to 66·k |
| pat_pos | output | 5 | Offset of output lane 0's block within the mapping repeat |

## Verification
The assertions assume that the upstream side offers only whole rows and that it treats a row as taken only on a cycle where `in_valid` and `in_ready` are both high. They also assume that the outputs need no backpressure, so every cycle with `out_valid` high drains N blocks. The stimulus keeps to these assumptions. Its driver holds a row until it sees `in_ready` and only then moves on. During idle gaps it puts deliberate garbage on the data lanes, so that a leak of that data would show up as a numbering error. The sweep runs the default N = 4 configuration through a single row, back-to-back rows, gapped rows, and a leftover of two blocks. It finishes with a reset taken while blocks are still stored.

// File: rtl/gbx_pkg.sv
// Package for the ten-to-N gearbox.
// Holds the block width and the arithmetic helpers that size the store and the
// mapping repeat. Assumes the helpers are called only on positive integers.
package gbx_pkg;

    localparam int GBX_BLK_W = 66;

    // Greatest common divisor by repeated remainder.
    function automatic int gbx_gcd(input int a, input int b);
        int x;
        int y;
        int t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    // Least common multiple; this is the period of the lane mapping.
    function automatic int gbx_lcm(input int a, input int b);
        return (a / gbx_gcd(a, b)) * b;
    endfunction

    // Width that can index n items, never less than one bit.
    function automatic int gbx_idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/gbx_ring.sv
// Block store for the gearbox.
// Writes a whole input row into a row-sized slot and reads N consecutive blocks
// from an N-sized slot. Assumes that DEPTH is a multiple of both IN_LANES and
// OUT_LANES, so no row and no output group ever wraps around the store. Also
// assumes that the caller asserts wr_en only when there is room for a row and
// rd_en only when at least OUT_LANES blocks are stored.
module gbx_ring #(
    parameter int BLK_W     = 66,
    parameter int IN_LANES  = 10,
    parameter int OUT_LANES = 4,
    parameter int DEPTH     = 20,
    localparam int IDX_W    = gbx_pkg::gbx_idx_w(DEPTH),
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IN_LANES*BLK_W-1:0]   wr_row,
    input  logic                        rd_en,
    output logic [CNT_W-1:0]            occ,
    output logic [IDX_W-1:0]            rd_base,
    output logic [DEPTH*BLK_W-1:0]      store_flat
);

    localparam int WR_SLOTS = DEPTH / IN_LANES;
    localparam int RD_SLOTS = DEPTH / OUT_LANES;
    localparam int WP_W     = gbx_pkg::gbx_idx_w(WR_SLOTS);
    localparam int RP_W     = gbx_pkg::gbx_idx_w(RD_SLOTS);
    localparam logic [WP_W-1:0]  WP_LAST = WP_W'(WR_SLOTS - 1);
    localparam logic [RP_W-1:0]  RP_LAST = RP_W'(RD_SLOTS - 1);
    localparam logic [CNT_W-1:0] ROW_CNT = CNT_W'(IN_LANES);
    localparam logic [CNT_W-1:0] GRP_CNT = CNT_W'(OUT_LANES);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ROOM_AT = CNT_W'(DEPTH - IN_LANES);

    logic [BLK_W-1:0] mem [DEPTH];
    logic [WP_W-1:0]  wr_slot;
    logic [RP_W-1:0]  rd_slot;

    // Write slot pointer: moves one row slot per accepted row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_slot <= '0;
        end else if (wr_en) begin
            wr_slot <= (wr_slot == WP_LAST) ? '0 : wr_slot + 1'b1;
        end
    end

    // Read slot pointer: moves one output group per emitted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_slot <= '0;
        end else if (rd_en) begin
            rd_slot <= (rd_slot == RP_LAST) ? '0 : rd_slot + 1'b1;
        end
    end

    // Row write: all lanes of the accepted row go into one slot.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int i = 0; i < IN_LANES; i++) begin
                mem[IDX_W'(int'(wr_slot) * IN_LANES + i)] <= wr_row[i*BLK_W +: BLK_W];
            end
        end
    end

    // Occupancy: add a row on write, remove a group on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ <= '0;
        end else begin
            occ <= occ + (wr_en ? ROW_CNT : '0) - (rd_en ? GRP_CNT : '0);
        end
    end

    // First block index of the group presented on the outputs.
    always_comb begin
        rd_base = IDX_W'(int'(rd_slot) * OUT_LANES);
    end

    // Flatten the store so that the lane pickers can index it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_flat
        assign store_flat[s*BLK_W +: BLK_W] = mem[s];
    end

    // R4: the store never holds more blocks than its depth.
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= MAX_CNT);

    // R4: a row is written only when all its blocks fit.
    p_row_room_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> occ <= ROOM_AT);

    // R3: a group is read only when it is complete.
    p_no_partial_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> occ >= GRP_CNT);

    // R9: with neither a write nor a read, held blocks stay held.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> $stable(occ));

endmodule

// File: rtl/gbx_lane_pick.sv
// Output lane selector for the gearbox.
// Output lane k takes the stored block at index rd_base + k. Assumes that
// rd_base is a multiple of OUT_LANES and that DEPTH is a multiple of
// OUT_LANES, so the index stays inside the store. The modulo is kept only as
// a guard.
module gbx_lane_pick #(
    parameter int BLK_W     = 66,
    parameter int OUT_LANES = 4,
    parameter int DEPTH     = 20,
    localparam int IDX_W    = gbx_pkg::gbx_idx_w(DEPTH)
) (
    input  logic [DEPTH*BLK_W-1:0]      store_flat,
    input  logic [IDX_W-1:0]            rd_base,
    output logic [OUT_LANES*BLK_W-1:0]  lanes_out
);

    for (genvar k = 0; k < OUT_LANES; k++) begin : g_lane
        int pick;
        // Select the block for this lane from the current group.
        always_comb begin
            pick = (int'(rd_base) + k) % DEPTH;
            lanes_out[k*BLK_W +: BLK_W] = store_flat[pick*BLK_W +: BLK_W];
        end
    end

endmodule

// File: rtl/gbx_pattern_pos.sv
// Mapping-repeat position counter.
// Counts the global number of the block on output lane 0, modulo the mapping
// period lcm(IN_LANES, OUT_LANES). Assumes that the period fits in POS_W bits
// and that step is pulsed once for each emitted output group.
module gbx_pattern_pos #(
    parameter int IN_LANES  = 10,
    parameter int OUT_LANES = 4,
    parameter int POS_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [POS_W-1:0] pos
);

    localparam int PERIOD = gbx_pkg::gbx_lcm(IN_LANES, OUT_LANES);
    localparam logic [POS_W:0] PER_V  = (POS_W+1)'(PERIOD);
    localparam logic [POS_W:0] STEP_V = (POS_W+1)'(OUT_LANES);

    logic [POS_W:0] sum;

    // Candidate next position before the wrap.
    always_comb begin
        sum = {1'b0, pos} + STEP_V;
    end

    // Advance by one group and wrap at the mapping period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (step) begin
            pos <= (sum >= PER_V) ? POS_W'(sum - PER_V) : POS_W'(sum);
        end
    end

    // R5: the position stays inside one mapping period.
    p_pos_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, pos} < PER_V);

endmodule

// File: rtl/ten_to_n_gearbox.sv
// Ten-to-N block lane gearbox (top).
// Accepts a row of IN_LANES blocks when the whole row fits in the store, and
// emits OUT_LANES consecutive blocks whenever that many are stored. Assumes
// that OUT_LANES divides DEPTH, that IN_LANES divides DEPTH, that DEPTH is at
// least IN_LANES + OUT_LANES, and that the output side never stalls.
module ten_to_n_gearbox #(
    parameter int OUT_LANES = 4,
    parameter int IN_LANES  = 10,
    parameter int BLK_W     = gbx_pkg::GBX_BLK_W,
    parameter int DEPTH     = 20,
    parameter int POS_W     = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [IN_LANES*BLK_W-1:0]   in_blocks,
    output logic                        out_valid,
    output logic [OUT_LANES*BLK_W-1:0]  out_blocks,
    output logic [POS_W-1:0]            pat_pos
);

    localparam int IDX_W  = gbx_pkg::gbx_idx_w(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int PERIOD = gbx_pkg::gbx_lcm(IN_LANES, OUT_LANES);
    localparam logic [CNT_W-1:0] ROOM_AT = CNT_W'(DEPTH - IN_LANES);
    localparam logic [CNT_W-1:0] GRP_CNT = CNT_W'(OUT_LANES);

    logic                     wr_fire;
    logic                     rd_fire;
    logic [CNT_W-1:0]         occ;
    logic [IDX_W-1:0]         rd_base;
    logic [DEPTH*BLK_W-1:0]   store_flat;

    // Handshake: take a row only when it fits; emit a group only when complete.
    always_comb begin
        in_ready  = (occ <= ROOM_AT);
        out_valid = (occ >= GRP_CNT);
        wr_fire   = in_valid && in_ready;
        rd_fire   = out_valid;
    end

    gbx_ring #(
        .BLK_W     (BLK_W),
        .IN_LANES  (IN_LANES),
        .OUT_LANES (OUT_LANES),
        .DEPTH     (DEPTH)
    ) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_fire),
        .wr_row     (in_blocks),
        .rd_en      (rd_fire),
        .occ        (occ),
        .rd_base    (rd_base),
        .store_flat (store_flat)
    );

    gbx_lane_pick #(
        .BLK_W     (BLK_W),
        .OUT_LANES (OUT_LANES),
        .DEPTH     (DEPTH)
    ) u_pick (
        .store_flat (store_flat),
        .rd_base    (rd_base),
        .lanes_out  (out_blocks)
    );

    gbx_pattern_pos #(
        .IN_LANES  (IN_LANES),
        .OUT_LANES (OUT_LANES),
        .POS_W     (POS_W)
    ) u_pos (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (rd_fire),
        .pos   (pat_pos)
    );

    // R1: a reset edge leaves an empty store and a zero position.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && in_ready && pat_pos == '0));

    // R5: the pattern counter agrees with the read pointer of the store.
    p_pos_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_base) % PERIOD) == int'(pat_pos));

    // R4: when input is refused, the store must already hold output data.
    p_refuse_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid);

    // R2: each emitted group moves the lane-0 position on by one group.
    p_group_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> (int'(pat_pos) == (int'($past(pat_pos)) + OUT_LANES) % PERIOD));

endmodule

// File: tb/ten_to_n_gearbox_test.sv
// Sweep bench for the ten-to-N gearbox in its default N = 4 configuration.
module ten_to_n_gearbox_test;

    localparam int N   = 4;
    localparam int L   = 10;
    localparam int W   = 66;
    localparam int D   = 20;
    localparam int PAT = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [L*W-1:0]   in_blocks = '0;
    logic             out_valid;
    logic [N*W-1:0]   out_blocks;
    logic [4:0]       pat_pos;

    int n_cmp = 0;
    int n_bad = 0;
    int acc_rows = 0;
    int emitted = 0;
    bit stream_on = 1'b0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    ten_to_n_gearbox uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_blocks  (in_blocks),
        .out_valid  (out_valid),
        .out_blocks (out_blocks),
        .pat_pos    (pat_pos)
    );

    // Expected content of global block b; lanes 0 and 1 of a row get a control header.
    function automatic logic [W-1:0] blk(input int b);
        logic [1:0] hdr;
        hdr = ((b % 10) < 2) ? 2'b10 : 2'b01;
        return {hdr, 32'(b) ^ 32'hC0DE0000, 32'(b * 40503 + 7)};
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Cycle monitor: compare against a model built from the accepted and emitted counts.
    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            int occ;
            occ = acc_rows * L - emitted;
            chk("R4 in_ready vs room", W'(in_ready), W'(occ <= D - L));
            chk("R3 out_valid vs stored", W'(out_valid), W'(occ >= N));
            if (stream_on && emitted > 0)
                chk("R7 no bubble while streaming", W'(out_valid), W'(1));
            if (out_valid) begin
                for (int k = 0; k < N; k++)
                    chk("R2 R6 lane block", out_blocks[k*W +: W], blk(emitted + k));
                chk("R5 pattern position", W'(pat_pos), W'(emitted % PAT));
                emitted += N;
            end
        end
    end

    // Offer one row until taken; garbage fills each idle gap cycle (R8).
    task automatic send_row(input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_blocks = {L{66'h3_DEAD_BEEF_0BAD_F00D}};
        end
        forever begin
            @(negedge clk);
            in_valid = 1'b1;
            for (int i = 0; i < L; i++)
                in_blocks[i*W +: W] = blk(acc_rows * L + i);
            #1;
            if (in_ready) begin
                acc_rows++;
                break;
            end
        end
    endtask

    task automatic go_idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            in_valid  = 1'b0;
            in_blocks = {L{66'h2_5555_AAAA_5555_AAAA}};
        end
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: state after reset
        chk("R1 out_valid after reset", W'(out_valid), W'(0));
        chk("R1 in_ready after reset", W'(in_ready), W'(1));
        chk("R1 pat_pos after reset", W'(pat_pos), W'(0));
        mon_on = 1'b1;

        // R9: one row leaves two blocks held
        send_row(0);
        go_idle(6);
        chk("R9 groups after one row", W'(emitted), W'(8));
        chk("R9 held blocks keep valid low", W'(out_valid), W'(0));
        send_row(0);
        go_idle(6);
        chk("R9 numbering continues", W'(emitted), W'(20));

        // R7: back-to-back rows
        send_row(0);
        stream_on = 1'b1;
        for (int r = 0; r < 11; r++) send_row(0);
        stream_on = 1'b0;
        go_idle(10);
        chk("R7 all streamed blocks out", W'(emitted), W'(140));

        // R8: gapped rows with garbage between
        for (int r = 0; r < 7; r++) send_row(r % 3 + 1);
        go_idle(10);
        chk("R8 R3 leftover held", W'(emitted), W'(208));
        chk("R3 valid low with two held", W'(out_valid), W'(0));

        // R1: reset with blocks still stored
        send_row(0);
        @(negedge clk);
        mon_on = 1'b0;
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        acc_rows = 0;
        emitted = 0;
        chk("R1 out_valid after busy reset", W'(out_valid), W'(0));
        chk("R1 in_ready after busy reset", W'(in_ready), W'(1));
        chk("R1 pat_pos after busy reset", W'(pat_pos), W'(0));
        mon_on = 1'b1;
        send_row(0);
        send_row(0);
        go_idle(8);
        chk("R2 numbering restarts after reset", W'(emitted), W'(20));

        summary();
        $finish;
    end

endmodule